// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

This block picks one clock reference out of a set of candidates (14 by default). Each candidate carries a 4-bit priority held in a small table inside the block, and a validity flag from external monitors. A candidate takes part in automatic selection only when its flag is high and its priority is usable. Among the candidates that take part, the lowest priority number wins. Candidates with the same number are ranked by the order in which they became eligible, with the oldest first.

A single mode register chooses between automatic selection and pinning one port by its number. In automatic mode a `revertive` input sets whether a better candidate takes over from a current one that is still healthy. When no candidate is usable, the block keeps the last index and drops the valid flag, so a downstream loop can go into holdover.

The decision is made again on every clock. The outputs are registered: the selected index, a selection-valid flag, and a one-cycle pulse that marks each change of index.

Top module: `clkref_selector`

## Requirements
- R1: The mode register is SEL_W bits wide (4 by default). A value of 0, of all ones, or of more than N_REFS selects automatic mode. A value v from 1 to N_REFS forces index v-1, and the valid flag then follows that port's `ref_valid` bit.
- R2: After synchronous reset the mode register is all ones (automatic), every priority is 0, and `sel_idx` = 0, `sel_ok` = 0, `sel_switch` = 0.
- R3: In automatic mode an input is eligible only when its valid bit is 1 and its priority is neither 4'b0000 nor 4'b1111. Among eligible inputs a lower priority number is preferred.
- R4: Eligible inputs of equal priority are ranked by the cycle in which they became eligible, oldest first. Inputs that become eligible in the same cycle are ranked by lower index first.
- R5: An input that becomes eligible again joins the back of its priority group and causes no switch away from an equal-priority current input.
- R6: When the current input stops being eligible and another is eligible, the best remaining input is selected, even when it has a lower priority. This holds in both modes.
- R7: With `revertive` = 1, an eligible input whose priority number is strictly lower than the current one's takes over.
- R8: With `revertive` = 0, the current input is kept for as long as it stays eligible.
- R9: When no input is eligible in automatic mode, `sel_ok` falls to 0 and `sel_idx` keeps its last value. When an input returns, the best one is selected.
- R10: `sel_switch` is high for exactly the cycles in which `sel_idx` differs from its value in the previous cycle.
- R11: A change on `ref_valid` or `revertive` before a clock edge shows in the outputs right after that edge. A table or mode write takes effect one edge later.
- R12: In forced mode, priorities and arrival order have no effect: a port with priority 0 can be forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | N_REFS | Per-input health flag from the monitors |
| revertive | input | 1 | 1: a better input takes over; 0: keep a healthy current input |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | SEL_W | 0 or all ones = automatic, 1..N_REFS = forced port number |
| prio_wr | input | 1 | Write strobe for the priority table |
| prio_waddr | input | IDX_W | Table entry to write (addresses at or above N_REFS are dropped) |
| prio_wdata | input | 4 | Priority value (1..14 usable, lower is better) |
| sel_idx | output | IDX_W | Selected input index |
| sel_ok | output | 1 | The selected input is currently usable |
| sel_switch | output | 1 | One-cycle pulse on every change of `sel_idx` |

## Verification
The assertions assume that `ref_valid` and `revertive` are synchronous to `clk` and that they and the write strobes hold no X or Z once reset is released. The age-order checks also rely on writes going only to addresses below N_REFS. The bench changes every input only on the falling edge and holds reset for several edges. It writes priorities only within the table, although the random phase does cover the reserved values 0 and 15 and every mode value.

// File: rtl/clkref_sel_pkg.sv
// Package: shared types and helpers for the clock reference selector.
// Assumes a 4-bit priority code in which both all-zero and all-one mean
// "not in the table".
package clkref_sel_pkg;
    localparam int PRIO_W = 4;
    typedef logic [PRIO_W-1:0] prio_t;

    // True when a priority code may take part in automatic selection.
    function automatic logic prio_usable(prio_t p);
        return (p != '0) && (p != '1);
    endfunction
endpackage

// File: rtl/clkref_sel_cfg.sv
// Module: holds the mode register and the per-input priority table, and
// decodes the mode into forced/automatic. Assumes single-cycle write
// strobes; an address at or above N_REFS is dropped.
module clkref_sel_cfg
    import clkref_sel_pkg::*;
#(
    parameter int N_REFS = 14,
    parameter int IDX_W  = $clog2(N_REFS),
    parameter int SEL_W  = $clog2(N_REFS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic [SEL_W-1:0]     mode_wdata,
    input  logic                 prio_wr,
    input  logic [IDX_W-1:0]     prio_waddr,
    input  prio_t                prio_wdata,
    output prio_t [N_REFS-1:0]   prio_tab,
    output logic                 forced,
    output logic [IDX_W-1:0]     force_idx
);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(N_REFS);

    logic [SEL_W-1:0] mode_q;

    // Mode register: resets to all ones, which means automatic.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '1;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    // One table entry per input, each written on its own address.
    for (genvar g = 0; g < N_REFS; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n) prio_tab[g] <= '0;
            else if (prio_wr && (prio_waddr == IDX_W'(g))) prio_tab[g] <= prio_wdata;
        end
    end

    // Decode the mode value into a forced flag and a zero-based index.
    always_comb begin
        forced    = (mode_q != '0) && (mode_q != '1) && (mode_q <= SEL_LIMIT);
        force_idx = IDX_W'(mode_q - SEL_W'(1));
    end

    // R1: a mode write is visible on the next edge.
    assert_mode_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_q == $past(mode_wdata)));
endmodule

// File: rtl/clkref_sel_order.sv
// Module: keeps the relative age of every pair of inputs. older[i][j] = 1
// means i became eligible before j. Newcomers go behind every input that
// was already eligible. Newcomers in the same cycle are ranked by lower
// index. The outputs give the order after this cycle's arrivals.
module clkref_sel_order #(
    parameter int N_REFS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_REFS-1:0]     elig,
    output logic [N_REFS*N_REFS-1:0] older_flat
);
    logic [N_REFS-1:0] elig_q;
    logic [N_REFS-1:0] arrive;
    logic [N_REFS-1:0] older_q [N_REFS];
    logic [N_REFS-1:0] older_d [N_REFS];

    // Remember last cycle's eligibility so that arrivals can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else elig_q <= elig;
    end

    assign arrive = elig & ~elig_q;

    // Work out the pairwise age relation after this cycle's arrivals.
    always_comb begin
        for (int i = 0; i < N_REFS; i++) begin
            for (int j = 0; j < N_REFS; j++) begin
                if (i == j)                       older_d[i][j] = 1'b0;
                else if (arrive[i] && arrive[j])  older_d[i][j] = (i < j);
                else if (arrive[i])               older_d[i][j] = 1'b0;
                else if (arrive[j])               older_d[i][j] = 1'b1;
                else                              older_d[i][j] = older_q[i][j];
            end
        end
    end

    // Store the age matrix.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_REFS; i++) begin
            if (!rst_n) older_q[i] <= '0;
            else older_q[i] <= older_d[i];
        end
    end

    // Flatten the matrix for the port.
    always_comb begin
        for (int i = 0; i < N_REFS; i++)
            older_flat[i*N_REFS +: N_REFS] = older_d[i];
    end

    // R4: two eligible inputs are always strictly ordered.
    for (genvar a = 0; a < N_REFS; a++) begin : g_chk_a
        for (genvar b = a + 1; b < N_REFS; b++) begin : g_chk_b
            assert_order_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (elig[a] && elig[b]) |-> (older_d[a][b] != older_d[b][a]));
            // R5: a pair that stays eligible keeps its order.
            assert_order_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (elig_q[a] && elig_q[b] && elig[a] && elig[b]) |->
                (older_d[a][b] == older_q[a][b]));
        end
    end
endmodule

// File: rtl/clkref_sel_pick.sv
// Module: finds the best eligible input. The lowest priority number wins,
// and age breaks a tie. Purely combinational; clk and rst_n only time the
// assertions. Assumes the age matrix is a strict order over the inputs
// that are eligible.
module clkref_sel_pick
    import clkref_sel_pkg::*;
#(
    parameter int N_REFS = 14,
    parameter int IDX_W  = $clog2(N_REFS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REFS-1:0]        elig,
    input  prio_t [N_REFS-1:0]       prio_tab,
    input  logic [N_REFS*N_REFS-1:0] older_flat,
    output logic                     any_elig,
    output logic [IDX_W-1:0]         best_idx,
    output prio_t                    best_prio
);
    logic [N_REFS-1:0] win;

    // An input wins when it beats every other eligible input.
    for (genvar i = 0; i < N_REFS; i++) begin : g_win
        logic [N_REFS-1:0] beats;
        for (genvar j = 0; j < N_REFS; j++) begin : g_pair
            if (i == j) begin : g_self
                assign beats[j] = 1'b1;
            end else begin : g_other
                assign beats[j] = !elig[j]
                    || (prio_tab[i] < prio_tab[j])
                    || ((prio_tab[i] == prio_tab[j]) && older_flat[i*N_REFS + j]);
            end
        end
        assign win[i] = elig[i] && (&beats);
    end

    // Encode the winner and report its priority.
    always_comb begin
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < N_REFS; i++) begin
            if (win[i]) begin
                best_idx  = IDX_W'(i);
                best_prio = prio_tab[i];
            end
        end
        any_elig = |win;
    end

    // R4: never more than one winner.
    assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
    // R3: some input wins whenever some input is eligible.
    assert_winner_exists_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> (|win));
endmodule

// File: rtl/clkref_selector.sv
// Module: top of the clock reference selector. Takes the mode and priority
// configuration, the age order and the best candidate, and applies the
// switch-over rules every cycle. Outputs are registered. Assumes ref_valid
// and revertive are synchronous to clk.
module clkref_selector
    import clkref_sel_pkg::*;
#(
    parameter int N_REFS = 14,
    parameter int IDX_W  = $clog2(N_REFS),
    parameter int SEL_W  = $clog2(N_REFS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REFS-1:0] ref_valid,
    input  logic              revertive,
    input  logic              mode_wr,
    input  logic [SEL_W-1:0]  mode_wdata,
    input  logic              prio_wr,
    input  logic [IDX_W-1:0]  prio_waddr,
    input  logic [3:0]        prio_wdata,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_ok,
    output logic              sel_switch
);
    prio_t [N_REFS-1:0]       prio_tab;
    logic                     forced;
    logic [IDX_W-1:0]         force_idx;
    logic [N_REFS-1:0]        elig;
    logic [N_REFS*N_REFS-1:0] older_flat;
    logic                     any_elig;
    logic [IDX_W-1:0]         best_idx;
    prio_t                    best_prio;
    logic [IDX_W-1:0]         idx_q, idx_d;
    logic                     ok_q, ok_d, sw_q;
    prio_t                    cur_prio;
    logic                     cur_elig;

    clkref_sel_cfg #(.N_REFS(N_REFS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .prio_wr(prio_wr), .prio_waddr(prio_waddr), .prio_wdata(prio_wdata),
        .prio_tab(prio_tab), .forced(forced), .force_idx(force_idx)
    );

    // An input is eligible when it is healthy and its priority is in the table.
    for (genvar g = 0; g < N_REFS; g++) begin : g_elig
        assign elig[g] = ref_valid[g] && prio_usable(prio_tab[g]);
    end

    clkref_sel_order #(.N_REFS(N_REFS)) u_order (
        .clk(clk), .rst_n(rst_n), .elig(elig), .older_flat(older_flat)
    );

    clkref_sel_pick #(.N_REFS(N_REFS), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig), .prio_tab(prio_tab),
        .older_flat(older_flat), .any_elig(any_elig),
        .best_idx(best_idx), .best_prio(best_prio)
    );

    assign cur_prio = prio_tab[idx_q];
    assign cur_elig = elig[idx_q];

    // Switch-over rules: forced, keep/revert, fail-over, or holdover.
    always_comb begin
        idx_d = idx_q;
        ok_d  = ok_q;
        if (forced) begin
            idx_d = force_idx;
            ok_d  = ref_valid[force_idx];
        end else if (ok_q && cur_elig) begin
            ok_d = 1'b1;
            if (revertive && any_elig && (best_prio < cur_prio)) idx_d = best_idx;
        end else if (any_elig) begin
            idx_d = best_idx;
            ok_d  = 1'b1;
        end else begin
            ok_d = 1'b0;
        end
    end

    // Output registers, with the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ok_q  <= 1'b0;
            sw_q  <= 1'b0;
        end else begin
            idx_q <= idx_d;
            ok_q  <= ok_d;
            sw_q  <= (idx_d != idx_q);
        end
    end

    assign sel_idx    = idx_q;
    assign sel_ok     = ok_q;
    assign sel_switch = sw_q;

    // R10: the pulse marks a change of index, and only that.
    assert_pulse_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> sw_q);
    assert_pulse_only_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |-> (idx_q != $past(idx_q)));
    // R1: a forced mode pins the index.
    assert_forced_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        forced |=> (idx_q == $past(force_idx)));
    // R8: non-revertive keeps a healthy current input.
    assert_nonrev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced && !revertive && ok_q && cur_elig) |=> (ok_q && $stable(idx_q)));
    // R9: nothing eligible means holdover.
    assert_holdover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced && !any_elig) |=> (!ok_q && $stable(idx_q)));
    // R6: losing the current input moves to the best remaining one.
    assert_failover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced && !(ok_q && cur_elig) && any_elig) |=> (ok_q && idx_q == $past(best_idx)));
endmodule

// File: tb/clkref_selector_bench.sv
module clkref_selector_bench;
    localparam int N = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ref_valid = '0;
    logic          revertive = 1'b0;
    logic          mode_wr = 1'b0;
    logic [3:0]    mode_wdata = '0;
    logic          prio_wr = 1'b0;
    logic [3:0]    prio_waddr = '0;
    logic [3:0]    prio_wdata = '0;
    logic [3:0]    sel_idx;
    logic          sel_ok;
    logic          sel_switch;

    int n_checks = 0;
    int n_fail = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R2";

    always #4 clk = ~clk;

    clkref_selector u_clkref_selector (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .revertive(revertive),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .prio_wr(prio_wr),
        .prio_waddr(prio_waddr), .prio_wdata(prio_wdata),
        .sel_idx(sel_idx), .sel_ok(sel_ok), .sel_switch(sel_switch)
    );

    // Behavioural reference: arrival stamps, a linear best search, rules.
    int m_mode;
    int m_prio [N];
    int m_stamp [N];
    bit m_was [N];
    int m_next;
    int m_idx;
    bit m_ok, m_sw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 15; m_next = 0; m_idx = 0; m_ok = 0; m_sw = 0;
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 0; m_stamp[i] = 0; m_was[i] = 0;
            end
        end else begin
            bit el [N];
            int best;
            int nidx;
            bit nok;
            best = -1;
            for (int i = 0; i < N; i++) begin
                el[i] = ref_valid[i] && (m_prio[i] != 0) && (m_prio[i] != 15);
                if (el[i] && !m_was[i]) begin
                    m_stamp[i] = m_next;
                    m_next++;
                end
                m_was[i] = el[i];
            end
            for (int i = 0; i < N; i++)
                if (el[i] && (best < 0 || m_prio[i] < m_prio[best] ||
                    (m_prio[i] == m_prio[best] && m_stamp[i] < m_stamp[best])))
                    best = i;
            nidx = m_idx; nok = m_ok;
            if (m_mode >= 1 && m_mode <= N) begin
                nidx = m_mode - 1; nok = ref_valid[nidx];
            end else if (m_ok && el[m_idx]) begin
                nok = 1;
                if (revertive && best >= 0 && m_prio[best] < m_prio[m_idx]) nidx = best;
            end else if (best >= 0) begin
                nidx = best; nok = 1;
            end else nok = 0;
            m_sw = (nidx != m_idx);
            m_idx = nidx; m_ok = nok;
            if (mode_wr) m_mode = mode_wdata;
            if (prio_wr && prio_waddr < N) m_prio[prio_waddr] = prio_wdata;
        end
    end

    // Compare with the reference on every falling edge.
    always @(negedge clk) begin
        if (model_on && !finished) begin
            n_checks++;
            if (sel_idx != m_idx[3:0] || sel_ok != m_ok || sel_switch != m_sw) begin
                n_fail++;
                $display("FAIL %s model: got idx=%0d ok=%0d sw=%0d exp idx=%0d ok=%0d sw=%0d",
                         cur_req, sel_idx, sel_ok, sel_switch, m_idx, m_ok, m_sw);
            end
        end
    end

    task automatic expect_out(input int idx, input bit ok, input bit sw, input string req);
        n_checks++;
        if (sel_idx != idx[3:0] || sel_ok != ok || sel_switch != sw) begin
            n_fail++;
            $display("FAIL %s: got idx=%0d ok=%0d sw=%0d exp idx=%0d ok=%0d sw=%0d",
                     req, sel_idx, sel_ok, sel_switch, idx, ok, sw);
        end
    endtask

    // One edge after driving, sampled at the falling edge.
    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_prio(input int a, input int p);
        prio_wr = 1; prio_waddr = a[3:0]; prio_wdata = p[3:0];
        step();
        prio_wr = 0;
    endtask

    task automatic wr_mode(input int v);
        mode_wr = 1; mode_wdata = v[3:0];
        step();
        mode_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung exp done");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        expect_out(0, 0, 0, "R2 reset");
        rst_n = 1;
        model_on = 1;
        step();
        // R2: the mode resets to automatic; nothing is eligible yet.
        expect_out(0, 0, 0, "R2 idle");
        cur_req = "R3";
        wr_prio(0, 5); wr_prio(1, 3); wr_prio(2, 3); wr_prio(3, 0);
        wr_prio(4, 15); wr_prio(5, 8);
        step();
        ref_valid = 14'b00_0000_0011_1111;
        step();
        // R3, R4: prio 3 beats 5/8; 1 and 2 arrive together, so 1 is older.
        expect_out(1, 1, 1, "R4 simultaneous arrival");
        cur_req = "R6";
        ref_valid[1] = 0;
        step();
        expect_out(2, 1, 1, "R6 fail to peer");
        step();
        expect_out(2, 1, 0, "R10 single pulse");
        cur_req = "R5";
        revertive = 1;
        ref_valid[1] = 1;
        step();
        expect_out(2, 1, 0, "R5 rejoin no switch");
        ref_valid[2] = 0;
        step();
        expect_out(1, 1, 1, "R4 next in order");
        ref_valid[1] = 0;
        step();
        expect_out(0, 1, 1, "R6 fail to lower priority");
        cur_req = "R8";
        revertive = 0;
        ref_valid[2] = 1;
        step();
        expect_out(0, 1, 0, "R8 non-revertive hold");
        cur_req = "R7";
        revertive = 1;
        step();
        expect_out(2, 1, 1, "R7 revert to better");
        cur_req = "R9";
        ref_valid = '0;
        step();
        expect_out(2, 0, 0, "R9 holdover");
        ref_valid[5] = 1;
        step();
        expect_out(5, 1, 1, "R9 recovery");
        cur_req = "R3";
        ref_valid = 14'b00_0000_0001_1000;
        step();
        expect_out(5, 0, 0, "R3 reserved priorities excluded");
        cur_req = "R12";
        wr_mode(4);
        expect_out(5, 0, 0, "R11 write latency");
        step();
        expect_out(3, 1, 1, "R12 force prio-0 port");
        ref_valid[3] = 0;
        step();
        expect_out(3, 0, 0, "R1 forced follows valid");
        cur_req = "R1";
        ref_valid[0] = 1;
        wr_mode(0);
        step();
        expect_out(0, 1, 1, "R1 zero means automatic");
        wr_mode(15);
        step();
        expect_out(0, 1, 0, "R1 all ones automatic");
        cur_req = "R11 random";
        for (int k = 0; k < 3000; k++) begin
            ref_valid = ref_valid ^ (14'(1) << $urandom_range(0, N - 1));
            if ($urandom_range(0, 9) == 0) revertive = ~revertive;
            prio_wr = ($urandom_range(0, 4) == 0);
            prio_waddr = 4'($urandom_range(0, N - 1));
            prio_wdata = 4'($urandom_range(0, 15));
            mode_wr = ($urandom_range(0, 40) == 0);
            mode_wdata = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            step();
        end
        prio_wr = 0; mode_wr = 0;
        step();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule